// File: doc/BRIEF.md
# Programmed-I/O FIFO Data Port

This block lets a host move bytes between its register bus and a local packet buffer without bus-master DMA. The host sets a 16-bit buffer pointer through two byte registers, then writes a control byte that starts a transfer and picks its direction. An 8-byte FIFO sits between the host and the buffer, and a ready flag in the status register tells the host when a whole 8-byte group can be moved. A full group is moved as four 16-bit accesses to the data port. A last group shorter than eight bytes is moved one byte at a time.

In the read direction the block fetches bytes from the buffer into the FIFO, one byte per cycle. In the write direction it drains host bytes from the FIFO into the buffer, one byte per cycle. The pointer advances by one for each byte that goes to or comes from the buffer. The buffer is addressed from a window base of 0x2000, and the pointer is reduced modulo the buffer depth. The host ends a transfer by writing the control byte back with the start bit clear. This empties the FIFO.

Top module: `pio_fifo_port`

## Requirements
- R1: After reset the control byte reads 0x00, the pointer reads 0x0000, and the status byte reads the revision value in bits 2:0 with every other bit 0.
- R2: Register offset 0x9 holds the pointer's upper byte and offset 0xA its lower byte; both read back what was written while idle, and writes to them are ignored while a transfer is running.
- R3: Control bit 7 starts a transfer and bit 6 selects host-to-buffer (1) or buffer-to-host (0); status bit 3 (busy) is high exactly while control bit 7 is set.
- R4: The status byte at offset 0x7 is laid out as bits 2:0 revision, bit 3 busy, bit 4 always 0, bit 5 overflow, bit 6 underflow, bit 7 ready.
- R5: In host-to-buffer transfers, ready is high when the FIFO is empty; the bytes written reach consecutive buffer locations in order, and the pointer advances by one per byte.
- R6: In buffer-to-host transfers, ready is high once the FIFO holds 8 prefetched bytes, and bytes come out in buffer order starting at the pointer.
- R7: A word access at offset 0xE moves two bytes, the earlier byte in data bits 7:0; a byte access at offset 0xE or 0xF moves one byte on bits 7:0.
- R8: Pointer value P selects buffer location (P - 0x2000) modulo the buffer depth.
- R9: A data-port read that asks for more bytes than the FIFO holds sets status bit 6 and removes no byte.
- R10: A data-port write that would take the FIFO past 8 bytes sets status bit 5 and stores none of its bytes.
- R11: Clearing the start bit empties the FIFO: ready and busy drop, and a fresh read transfer starts at the pointer where prefetch stopped.
- R12: The overflow and underflow flags stay set until the next start of a transfer, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_off | input | 4 | Register offset of the host access |
| host_we | input | 1 | Host write strobe, one cycle per access |
| host_re | input | 1 | Host read strobe, one cycle per access |
| host_word | input | 1 | Access is 16 bits wide (data port upper offset only) |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data for the current offset, combinational |
| ram_we | output | 1 | Buffer write strobe for this cycle |
| ram_re | output | 1 | Buffer read strobe for this cycle |

## Verification
Read data is combinational, so the bench samples it in the same cycle as the access, before the clock edge. Register and status effects of an access appear one cycle later, and the bench samples them on the next access. Fill and drain run one byte per cycle, and their timing depends on how far the FIFO has filled or emptied. The bench therefore never waits a fixed number of cycles for them; it polls the ready bit with a bounded retry count before each group. The overflow case depends on exact timing. Seven word writes on consecutive edges meet a drain of one byte per cycle, so the FIFO reaches seven bytes just before the seventh write, and that write is the one dropped.

// File: rtl/pio_pkg.sv
package pio_pkg;
    // Register offsets inside the host window
    localparam logic [3:0] OFF_CTRL   = 4'h6;
    localparam logic [3:0] OFF_STAT   = 4'h7;
    localparam logic [3:0] OFF_PTR_HI = 4'h9;
    localparam logic [3:0] OFF_PTR_LO = 4'hA;
    localparam logic [3:0] OFF_DAT_HI = 4'hE;
    localparam logic [3:0] OFF_DAT_LO = 4'hF;

    // Control bits
    localparam int CB_GO  = 7;
    localparam int CB_DIR = 6;

    // FIFO geometry
    localparam int FIFO_BYTES = 8;
endpackage

// File: rtl/pio_byte_fifo.sv
module pio_byte_fifo #(
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic [1:0]                 push_n,
    input  logic [7:0]                 push_lo,
    input  logic [7:0]                 push_hi,
    input  logic [1:0]                 pop_n,
    output logic [$clog2(DEPTH):0]     count,
    output logic [7:0]                 head_lo,
    output logic [7:0]                 head_hi
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = PW + 1;

    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [CW-1:0] cnt;
    } fst_t;

    fst_t f_d, f_q;
    logic [7:0] mem [DEPTH];

    always_comb begin
        f_d = f_q;
        if (flush) begin
            f_d.wp  = '0;
            f_d.rp  = '0;
            f_d.cnt = '0;
        end else begin
            f_d.wp  = f_q.wp + PW'(push_n);
            f_d.rp  = f_q.rp + PW'(pop_n);
            f_d.cnt = f_q.cnt + CW'(push_n) - CW'(pop_n);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    always_ff @(posedge clk) begin
        if (!flush && push_n != 2'd0) begin
            mem[f_q.wp] <= push_lo;
            if (push_n == 2'd2) mem[f_q.wp + PW'(1)] <= push_hi;
        end
    end

    assign count   = f_q.cnt;
    assign head_lo = mem[f_q.rp];
    assign head_hi = mem[f_q.rp + PW'(1)];
endmodule

// File: rtl/pio_buf_ram.sv
module pio_buf_ram #(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          we,
    input  logic          re,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);
    localparam int WORDS = 1 << AW;
    logic [7:0] cells [WORDS];

    always_ff @(posedge clk) begin
        if (we) cells[addr] <= wdata;
        if (re) rdata <= cells[addr];
    end
endmodule

// File: rtl/pio_fifo_port.sv
module pio_fifo_port #(
    parameter int          BUF_AW   = 11,
    parameter logic [2:0]  REV      = 3'd1,
    parameter logic [15:0] WIN_BASE = 16'h2000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  host_off,
    input  logic        host_we,
    input  logic        host_re,
    input  logic        host_word,
    input  logic [15:0] host_wdata,
    output logic [15:0] host_rdata,
    output logic        ram_we,
    output logic        ram_re
);
    import pio_pkg::*;

    localparam int FD = FIFO_BYTES;
    localparam int CW = $clog2(FD) + 1;

    typedef struct packed {
        logic [15:0] ptr;
        logic [7:0]  ctrl;
        logic        ovf;
        logic        unf;
        logic        infl;
    } st_t;

    st_t s_d, s_q;

    logic          flush;
    logic [1:0]    push_n, pop_n, acc_n;
    logic [7:0]    push_lo, push_hi;
    logic [CW-1:0] fifo_cnt;
    logic [7:0]    head_lo, head_hi, ram_rdata;
    logic [BUF_AW-1:0] ram_idx;
    logic [15:0]   win_off;
    logic          busy, wr_dir, rd_mode, wr_mode, ready, is_data;
    logic          ovf_flag, unf_flag;
    logic [15:0]   cur_ptr;
    logic [7:0]    status;

    always_comb begin
        s_d     = s_q;
        flush   = 1'b0;
        push_n  = 2'd0;
        push_lo = ram_rdata;
        push_hi = 8'h00;
        pop_n   = 2'd0;
        ram_we  = 1'b0;
        ram_re  = 1'b0;
        busy    = s_q.ctrl[CB_GO];
        wr_dir  = s_q.ctrl[CB_DIR];
        wr_mode = busy && wr_dir;
        rd_mode = busy && !wr_dir;
        is_data = (host_off == OFF_DAT_HI) || (host_off == OFF_DAT_LO);
        acc_n   = (host_word && host_off == OFF_DAT_HI) ? 2'd2 : 2'd1;

        // Host register writes
        if (host_we) begin
            unique case (host_off)
                OFF_CTRL: begin
                    s_d.ctrl = host_wdata[7:0];
                    if (!host_wdata[CB_GO]) flush = 1'b1;
                    if (host_wdata[CB_GO] && !busy) begin
                        flush   = 1'b1;
                        s_d.ovf = 1'b0;
                        s_d.unf = 1'b0;
                    end
                end
                OFF_PTR_HI: if (!busy) s_d.ptr[15:8] = host_wdata[7:0];
                OFF_PTR_LO: if (!busy) s_d.ptr[7:0]  = host_wdata[7:0];
                OFF_DAT_HI, OFF_DAT_LO: begin
                    if (wr_mode) begin
                        if (fifo_cnt + CW'(acc_n) <= CW'(FD)) begin
                            push_n  = acc_n;
                            push_lo = host_wdata[7:0];
                            push_hi = host_wdata[15:8];
                        end else begin
                            s_d.ovf = 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end

        // Host data-port reads
        if (host_re && is_data && rd_mode) begin
            if (fifo_cnt >= CW'(acc_n)) pop_n = acc_n;
            else                        s_d.unf = 1'b1;
        end

        // Buffer-to-host prefetch: one byte per cycle, one fetch in flight
        s_d.infl = 1'b0;
        if (rd_mode && !flush) begin
            if (s_q.infl) begin
                push_n  = 2'd1;
                push_lo = ram_rdata;
            end
            if (fifo_cnt + CW'(s_q.infl) < CW'(FD)) begin
                ram_re   = 1'b1;
                s_d.infl = 1'b1;
                s_d.ptr  = s_q.ptr + 16'd1;
            end
        end

        // Host-to-buffer drain: one byte per cycle
        if (wr_mode && !flush && fifo_cnt != '0) begin
            ram_we  = 1'b1;
            pop_n   = 2'd1;
            s_d.ptr = s_q.ptr + 16'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign win_off = s_q.ptr - WIN_BASE;
    assign ram_idx = win_off[BUF_AW-1:0];
    assign ready   = rd_mode ? (fifo_cnt == CW'(FD)) : (wr_mode ? (fifo_cnt == '0) : 1'b0);
    assign status  = {ready, s_q.unf, s_q.ovf, 1'b0, busy, REV};
    assign ovf_flag = s_q.ovf;
    assign unf_flag = s_q.unf;
    assign cur_ptr  = s_q.ptr;

    always_comb begin
        unique case (host_off)
            OFF_CTRL:   host_rdata = {8'h00, s_q.ctrl};
            OFF_STAT:   host_rdata = {8'h00, status};
            OFF_PTR_HI: host_rdata = {8'h00, s_q.ptr[15:8]};
            OFF_PTR_LO: host_rdata = {8'h00, s_q.ptr[7:0]};
            OFF_DAT_HI: host_rdata = host_word ? {head_hi, head_lo} : {8'h00, head_lo};
            OFF_DAT_LO: host_rdata = {8'h00, head_lo};
            default:    host_rdata = 16'h0000;
        endcase
    end

    pio_byte_fifo #(.DEPTH(FD)) i_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .push_n  (push_n),
        .push_lo (push_lo),
        .push_hi (push_hi),
        .pop_n   (pop_n),
        .count   (fifo_cnt),
        .head_lo (head_lo),
        .head_hi (head_hi)
    );

    pio_buf_ram #(.AW(BUF_AW)) i_ram (
        .clk   (clk),
        .we    (ram_we),
        .re    (ram_re),
        .addr  (ram_idx),
        .wdata (head_lo),
        .rdata (ram_rdata)
    );
endmodule

// File: rtl/pio_fifo_port_chk.sv
module pio_fifo_port_chk #(
    parameter int CW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          host_we,
    input logic [3:0]    host_off,
    input logic [15:0]   host_wdata,
    input logic          busy,
    input logic          wr_dir,
    input logic          ovf,
    input logic          ram_we,
    input logic          ram_re,
    input logic [15:0]   ptr,
    input logic [CW-1:0] cnt
);
    // FIFO never holds more than eight bytes
    assert_cnt_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(8));

    // Buffer writes only happen in a running host-to-buffer transfer
    assert_ramwe_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (busy && wr_dir));

    // Each buffer access advances the pointer by one
    assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we || ram_re) |=> (ptr == $past(ptr) + 16'd1));

    // While busy, the pointer only moves with buffer traffic
    assert_ptr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ram_we && !ram_re) |=> $stable(ptr));

    // A new transfer begins with an empty FIFO
    assert_start_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (cnt == '0));

    // Reads and writes of the buffer never coincide
    assert_ram_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_we && ram_re));

    // Overflow flag is sticky until a start write
    assert_ovf_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !(host_we && host_off == 4'h6 && host_wdata[7] && !busy)) |=> ovf);
endmodule

bind pio_fifo_port pio_fifo_port_chk #(.CW(CW)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_we    (host_we),
    .host_off   (host_off),
    .host_wdata (host_wdata),
    .busy       (busy),
    .wr_dir     (wr_dir),
    .ovf        (ovf_flag),
    .ram_we     (ram_we),
    .ram_re     (ram_re),
    .ptr        (cur_ptr),
    .cnt        (fifo_cnt)
);

// File: tb/test_pio_fifo_port.sv
module test_pio_fifo_port;
    localparam int CLK_PERIOD = 10;
    localparam int AW         = 11;
    localparam int DEPTH      = 1 << AW;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  host_off = 4'h0;
    logic        host_we = 1'b0;
    logic        host_re = 1'b0;
    logic        host_word = 1'b0;
    logic [15:0] host_wdata = 16'h0;
    logic [15:0] host_rdata;
    logic        ram_we, ram_re;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pio_fifo_port #(.BUF_AW(AW), .REV(3'd1)) i_pio_fifo_port (
        .clk(clk), .rst_n(rst_n), .host_off(host_off), .host_we(host_we),
        .host_re(host_re), .host_word(host_word), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .ram_we(ram_we), .ram_re(ram_re)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] off, input logic [15:0] d, input logic word);
        @(negedge clk);
        host_off = off; host_wdata = d; host_word = word; host_we = 1'b1;
        @(posedge clk); #1;
        host_we = 1'b0; host_word = 1'b0;
    endtask

    task automatic rd(input logic [3:0] off, input logic word, output logic [15:0] d);
        @(negedge clk);
        host_off = off; host_word = word; host_re = 1'b1;
        #1 d = host_rdata;
        @(posedge clk); #1;
        host_re = 1'b0; host_word = 1'b0;
    endtask

    task automatic set_ptr(input logic [15:0] p);
        wr(4'h9, {8'h00, p[15:8]}, 1'b0);
        wr(4'hA, {8'h00, p[7:0]}, 1'b0);
    endtask

    task automatic get_ptr(output logic [15:0] p);
        logic [15:0] h, l;
        rd(4'h9, 1'b0, h);
        rd(4'hA, 1'b0, l);
        p = {h[7:0], l[7:0]};
    endtask

    task automatic wait_ready(input string req);
        logic [15:0] s;
        bit ok = 1'b0;
        for (int i = 0; i < 200; i++) begin
            rd(4'h7, 1'b0, s);
            if (s[7]) begin ok = 1'b1; break; end
        end
        chk(req, {15'd0, ok}, 16'd1);
    endtask

    task automatic t_reset;
        logic [15:0] v;
        rd(4'h7, 1'b0, v); chk("R1 status", v, 16'h0001);
        rd(4'h6, 1'b0, v); chk("R1 ctrl", v, 16'h0000);
        get_ptr(v);        chk("R1 ptr", v, 16'h0000);
    endtask

    task automatic t_ptr;
        logic [15:0] v;
        set_ptr(16'h2134);
        get_ptr(v); chk("R2 ptr readback", v, 16'h2134);
    endtask

    // 11 bytes A0..AA at 0x2010: four words then three single bytes
    task automatic t_write_read;
        logic [15:0] v;
        set_ptr(16'h2010);
        wr(4'h6, 16'h00C0, 1'b0);
        rd(4'h6, 1'b0, v); chk("R3 ctrl readback", v, 16'h00C0);
        rd(4'h7, 1'b0, v); chk("R4 R5 status write idle", v, 16'h0089);
        wr(4'hA, 16'h0000, 1'b0);
        get_ptr(v); chk("R2 ptr write ignored busy", v, 16'h2010);
        for (int i = 0; i < 4; i++)
            wr(4'hE, {8'hA1 + 8'(2*i), 8'hA0 + 8'(2*i)}, 1'b1);
        wait_ready("R5 drain ready");
        wr(4'hE, 16'h00A8, 1'b0);
        wr(4'hF, 16'h00A9, 1'b0);
        wr(4'hF, 16'h00AA, 1'b0);
        wait_ready("R5 drain ready 2");
        get_ptr(v); chk("R5 ptr advance", v, 16'h201B);
        wr(4'h6, 16'h0000, 1'b0);
        rd(4'h7, 1'b0, v); chk("R3 status stop", v, 16'h0001);

        set_ptr(16'h2010);
        wr(4'h6, 16'h0080, 1'b0);
        wait_ready("R6 fill ready");
        rd(4'h7, 1'b0, v); chk("R4 R6 status read ready", v, 16'h0089);
        for (int i = 0; i < 4; i++) begin
            rd(4'hE, 1'b1, v);
            chk("R6 R7 word read", v, {8'hA1 + 8'(2*i), 8'hA0 + 8'(2*i)});
        end
        wait_ready("R6 refill ready");
        rd(4'hE, 1'b0, v); chk("R7 byte read hi off", v, 16'h00A8);
        rd(4'hF, 1'b0, v); chk("R7 byte read lo off", v, 16'h00A9);
        rd(4'hF, 1'b0, v); chk("R6 last byte", v, 16'h00AA);
        wr(4'h6, 16'h0000, 1'b0);
    endtask

    task automatic t_window;
        logic [15:0] v;
        set_ptr(16'h2000 + 16'(DEPTH));
        wr(4'h6, 16'h00C0, 1'b0);
        wr(4'hE, 16'h2211, 1'b1);
        wait_ready("R8 drain");
        wr(4'h6, 16'h0000, 1'b0);
        set_ptr(16'h2000);
        wr(4'h6, 16'h0080, 1'b0);
        wait_ready("R8 fill");
        rd(4'hE, 1'b1, v); chk("R8 window wrap", v, 16'h2211);
        wr(4'h6, 16'h0000, 1'b0);
    endtask

    task automatic t_underflow;
        logic [15:0] v;
        set_ptr(16'h2010);
        wr(4'h6, 16'h0080, 1'b0);
        rd(4'hF, 1'b0, v);
        rd(4'h7, 1'b0, v); chk("R9 underflow flag", {8'h00, v[7:0] & 8'h40}, 16'h0040);
        wait_ready("R9 fill");
        for (int i = 0; i < 8; i++) begin
            rd(4'hF, 1'b0, v); chk("R9 no byte lost", v, {8'h00, 8'hA0 + 8'(i)});
        end
        wait_ready("R12 refill");
        rd(4'h7, 1'b0, v); chk("R12 underflow sticky", v, 16'h00C9);
        wr(4'h6, 16'h0000, 1'b0);
        rd(4'h7, 1'b0, v); chk("R12 sticky when idle", v, 16'h0041);
        wr(4'h6, 16'h00C0, 1'b0);
        rd(4'h7, 1'b0, v); chk("R12 cleared on start", v, 16'h0089);
        wr(4'h6, 16'h0000, 1'b0);
    endtask

    task automatic t_overflow;
        logic [15:0] v;
        set_ptr(16'h2100);
        wr(4'h6, 16'h00C0, 1'b0);
        for (int i = 0; i < 7; i++)
            wr(4'hE, {8'h41 + 8'(2*i), 8'h40 + 8'(2*i)}, 1'b1);
        wait_ready("R10 drain");
        rd(4'h7, 1'b0, v); chk("R10 overflow flag", v, 16'h00A9);
        get_ptr(v); chk("R10 dropped bytes", v, 16'h210C);
        wr(4'h6, 16'h0000, 1'b0);
        set_ptr(16'h2100);
        wr(4'h6, 16'h0080, 1'b0);
        wait_ready("R10 fill");
        for (int i = 0; i < 8; i++) begin
            rd(4'hF, 1'b0, v); chk("R10 stored data", v, {8'h00, 8'h40 + 8'(i)});
        end
        wr(4'h6, 16'h0000, 1'b0);
    endtask

    task automatic t_flush;
        logic [15:0] v;
        set_ptr(16'h2010);
        wr(4'h6, 16'h0080, 1'b0);
        wait_ready("R11 fill");
        wr(4'h6, 16'h0000, 1'b0);
        rd(4'h7, 1'b0, v); chk("R11 status after stop", v, 16'h0001);
        get_ptr(v); chk("R11 ptr after prefetch", v, 16'h2018);
        wr(4'h6, 16'h0080, 1'b0);
        wait_ready("R11 refill");
        rd(4'hF, 1'b0, v); chk("R11 fresh data", v, 16'h00A8);
        wr(4'h6, 16'h0000, 1'b0);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_ptr();
        t_write_read();
        t_window();
        t_underflow();
        t_overflow();
        t_flush();
        summary();
    end
endmodule